// File: doc/BRIEF.md
# Load Hazard Check and Issue

This block decides, every cycle, what each entry of a load queue may do. It checks every load against every store that precedes it in program order, and finds any store that could still write the load's address. Out of those results it does one of three things for each load. It can satisfy the load at once with data forwarded from the store queue. It can let the load compete for the single memory read port. Or it can hold the load back until the hazard clears.

Queue allocation, dispatch and the address comparators lie outside the block. The surrounding queue logic supplies the per-entry status bits, the queue head pointers, a load-by-store program-order matrix and a load-by-store address-equality matrix. The block keeps one register per load: the "issued" bit. This bit records that the load has been served, either by forwarding or by an accepted read request. A build parameter removes the whole forwarding path. A load that hits a hazard then waits until the store has completed.

Top module: `ld_hazard_issue`

## Requirements
- R1: Load i conflicts with store j only when all of these hold: store j is allocated; store j is not completed; store j is older than load i (`st_older[i][j]`=1); and either `addr_same[i][j]`=1 or store j's address is not yet valid. A completed or unallocated store never blocks a load.
- R2: A load that conflicts with any store never raises a read request.
- R3: With forwarding built in, load i forwards when three things hold. First, it has at least one conflict. Second, the youngest conflicting store has a valid address equal to the load's address. Third, that store has valid data. Youngest means furthest from `st_head` in circular store order. `byp_valid[i]` is then 1 and `byp_data[i]` equals that store's data.
- R4: If the youngest conflicting store has an unknown address or missing data, the load neither forwards nor requests memory.
- R5: Forwarding only happens for a load that is allocated, has a valid address and is not issued.
- R6: With `BYP_EN`=0, `byp_valid` stays zero. A conflicting load waits until no conflict remains, then requests memory.
- R7: A load may request memory only when it is allocated, has a valid address, is not issued, is not forwarding in this cycle and has no conflict.
- R8: At most one read request is raised per cycle. The winner is the first eligible load found by searching circularly from `ld_head` upward, with index wrapping from NL-1 to 0.
- R9: `rd_addr` is the winner's address, and `rd_id` is the winner's queue index.
- R10: The issued bit of load i is set on the clock edge after one of two events. Either load i forwards, or load i is the read winner while `rd_ready`=1. A request held without `rd_ready` leaves the bit clear. `ld_clear[i]`=1 clears the bit and takes priority over a set.
- R11: During and right after synchronous active-high reset, all issued bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_alloc | input | NL | Load entry allocated |
| ld_addr_valid | input | NL | Load address known |
| ld_addr | input | NL×AW | Load addresses |
| ld_head | input | log2(NL) | Oldest load entry |
| ld_clear | input | NL | Entry reallocated: clear its issued bit |
| st_alloc | input | NS | Store entry allocated |
| st_done | input | NS | Store has completed in memory |
| st_addr_valid | input | NS | Store address known |
| st_data_valid | input | NS | Store data known |
| st_data | input | NS×DW | Store data |
| st_head | input | log2(NS) | Oldest store entry |
| st_older | input | NL×NS | [i][j]=1: store j precedes load i |
| addr_same | input | NL×NS | [i][j]=1: addresses of load i and store j are equal |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_valid | output | 1 | Read request present |
| rd_addr | output | AW | Read address |
| rd_id | output | log2(NL) | Read request tag: load index |
| byp_valid | output | NL | Load served by forwarding this cycle |
| byp_data | output | NL×DW | Forwarded data per load |
| ld_issued | output | NL | Issued bit per load |

## Verification
The assertions assume that the status inputs hold still across each clock edge. They also assume that `addr_same` is meaningful only where both addresses are valid, which is why the forwarding check also requires the store's address to be valid. The bench changes its inputs only at the falling edge. It draws the matrices and status bits freely, because the block must give a defined answer for any combination, and it pulses `ld_clear` so that issued entries come back into play. A behavioural model then predicts every output from the same inputs, including the effect of the issued state.

// File: rtl/lhq_pkg.sv
package lhq_pkg;

    localparam int unsigned LHQ_DEF_DEPTH = 16;

    // position of an entry counted from a circular head pointer
    function automatic int unsigned ring_pos(input int unsigned head,
                                             input int unsigned step,
                                             input int unsigned depth);
        return (head + step) % depth;
    endfunction

    typedef enum logic [1:0] {
        LD_WAIT = 2'd0,
        LD_FWD  = 2'd1,
        LD_READ = 2'd2
    } ld_action_e;

endpackage

// File: rtl/lhq_conflict.sv
module lhq_conflict #(
    parameter int unsigned NL = 16,
    parameter int unsigned NS = 16
) (
    input  logic [NS-1:0]         st_alloc,
    input  logic [NS-1:0]         st_done,
    input  logic [NS-1:0]         st_addr_valid,
    input  logic [NL-1:0][NS-1:0] st_older,
    input  logic [NL-1:0][NS-1:0] addr_same,
    output logic [NL-1:0][NS-1:0] conf,
    output logic [NL-1:0]         conf_any
);
    // R1: pending, older store with matching or unknown address
    logic [NS-1:0] st_pending;
    assign st_pending = st_alloc & ~st_done;

    for (genvar i = 0; i < NL; i++) begin : g_row
        assign conf[i]     = st_pending & st_older[i] & (addr_same[i] | ~st_addr_valid);
        assign conf_any[i] = |conf[i];
    end
endmodule

// File: rtl/lhq_fwd.sv
module lhq_fwd #(
    parameter int unsigned NL     = 16,
    parameter int unsigned NS     = 16,
    parameter int unsigned DW     = 32,
    parameter bit          BYP_EN = 1'b1,
    localparam int unsigned SW    = $clog2(NS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NL-1:0][NS-1:0] conf,
    input  logic [NL-1:0][NS-1:0] addr_same,
    input  logic [NS-1:0]         st_addr_valid,
    input  logic [NS-1:0]         st_data_valid,
    input  logic [NS-1:0][DW-1:0] st_data,
    input  logic [SW-1:0]         st_head,
    input  logic [NL-1:0]         ld_alloc,
    input  logic [NL-1:0]         ld_addr_valid,
    input  logic [NL-1:0]         ld_issued,
    output logic [NL-1:0]         byp,
    output logic [NL-1:0][DW-1:0] byp_data
);
    import lhq_pkg::*;

    if (BYP_EN) begin : g_fwd
        logic [NL-1:0][SW-1:0] young;
        logic [NL-1:0]         found;

        // R3: last conflicting store in circular order is the youngest
        always_comb begin
            for (int i = 0; i < NL; i++) begin
                young[i] = '0;
                found[i] = 1'b0;
                for (int k = 0; k < NS; k++) begin
                    if (conf[i][ring_pos(int'(st_head), k, NS)]) begin
                        young[i] = SW'(ring_pos(int'(st_head), k, NS));
                        found[i] = 1'b1;
                    end
                end
            end
        end

        for (genvar i = 0; i < NL; i++) begin : g_ld
            assign byp[i] = found[i] & ld_alloc[i] & ld_addr_valid[i] & ~ld_issued[i]
                          & addr_same[i][young[i]] & st_addr_valid[young[i]]
                          & st_data_valid[young[i]];
            assign byp_data[i] = st_data[young[i]];
        end
    end else begin : g_nofwd
        // R6: path removed, constant zero
        assign byp      = '0;
        assign byp_data = '0;
    end

    p_byp_qual_r5: assert property (@(posedge clk) disable iff (rst)
        (byp & ~(ld_alloc & ld_addr_valid & ~ld_issued)) == '0);
endmodule

// File: rtl/lhq_arb.sv
module lhq_arb #(
    parameter int unsigned NL = 16,
    localparam int unsigned IW = $clog2(NL)
) (
    input  logic [NL-1:0] req,
    input  logic [IW-1:0] head,
    output logic [NL-1:0] grant
);
    import lhq_pkg::*;

    // R8: first requester at or after head, wrapping
    always_comb begin
        logic taken;
        grant = '0;
        taken = 1'b0;
        for (int k = 0; k < NL; k++) begin
            if (!taken && req[ring_pos(int'(head), k, NL)]) begin
                grant[ring_pos(int'(head), k, NL)] = 1'b1;
                taken = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ld_hazard_issue.sv
module ld_hazard_issue #(
    parameter int unsigned NL     = lhq_pkg::LHQ_DEF_DEPTH,
    parameter int unsigned NS     = lhq_pkg::LHQ_DEF_DEPTH,
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = 32,
    parameter bit          BYP_EN = 1'b1,
    localparam int unsigned IW    = $clog2(NL),
    localparam int unsigned SW    = $clog2(NS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NL-1:0]         ld_alloc,
    input  logic [NL-1:0]         ld_addr_valid,
    input  logic [NL-1:0][AW-1:0] ld_addr,
    input  logic [IW-1:0]         ld_head,
    input  logic [NL-1:0]         ld_clear,
    input  logic [NS-1:0]         st_alloc,
    input  logic [NS-1:0]         st_done,
    input  logic [NS-1:0]         st_addr_valid,
    input  logic [NS-1:0]         st_data_valid,
    input  logic [NS-1:0][DW-1:0] st_data,
    input  logic [SW-1:0]         st_head,
    input  logic [NL-1:0][NS-1:0] st_older,
    input  logic [NL-1:0][NS-1:0] addr_same,
    input  logic                  rd_ready,
    output logic                  rd_valid,
    output logic [AW-1:0]         rd_addr,
    output logic [IW-1:0]         rd_id,
    output logic [NL-1:0]         byp_valid,
    output logic [NL-1:0][DW-1:0] byp_data,
    output logic [NL-1:0]         ld_issued
);
    import lhq_pkg::*;

    logic [NL-1:0][NS-1:0] conf;
    logic [NL-1:0]         conf_any;
    logic [NL-1:0]         rd_req;
    logic [NL-1:0]         grant;
    logic [NL-1:0]         hs_vec;
    ld_action_e            act [NL];

    lhq_conflict #(.NL(NL), .NS(NS)) u_conf (
        .st_alloc      (st_alloc),
        .st_done       (st_done),
        .st_addr_valid (st_addr_valid),
        .st_older      (st_older),
        .addr_same     (addr_same),
        .conf          (conf),
        .conf_any      (conf_any)
    );

    lhq_fwd #(.NL(NL), .NS(NS), .DW(DW), .BYP_EN(BYP_EN)) u_fwd (
        .clk           (clk),
        .rst           (rst),
        .conf          (conf),
        .addr_same     (addr_same),
        .st_addr_valid (st_addr_valid),
        .st_data_valid (st_data_valid),
        .st_data       (st_data),
        .st_head       (st_head),
        .ld_alloc      (ld_alloc),
        .ld_addr_valid (ld_addr_valid),
        .ld_issued     (ld_issued),
        .byp           (byp_valid),
        .byp_data      (byp_data)
    );

    // R7: per-load action
    for (genvar i = 0; i < NL; i++) begin : g_act
        always_comb begin
            if (byp_valid[i])
                act[i] = LD_FWD;
            else if (ld_alloc[i] && ld_addr_valid[i] && !ld_issued[i] && !conf_any[i])
                act[i] = LD_READ;
            else
                act[i] = LD_WAIT;
        end
        assign rd_req[i] = (act[i] == LD_READ);
    end

    lhq_arb #(.NL(NL)) u_arb (
        .req   (rd_req),
        .head  (ld_head),
        .grant (grant)
    );

    // R9: one-hot selection of address and index
    always_comb begin
        rd_addr = '0;
        rd_id   = '0;
        for (int i = 0; i < NL; i++) begin
            if (grant[i]) begin
                rd_addr = rd_addr | ld_addr[i];
                rd_id   = rd_id | IW'(i);
            end
        end
    end
    assign rd_valid = |grant;
    assign hs_vec   = grant & {NL{rd_ready}};

    // R10, R11: issued state, clear has priority
    always_ff @(posedge clk) begin
        if (rst) ld_issued <= '0;
        else     ld_issued <= (ld_issued | hs_vec | byp_valid) & ~ld_clear;
    end

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_rd_no_conflict_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !conf_any[rd_id]);
    p_byp_needs_conf_r3: assert property (@(posedge clk) disable iff (rst)
        (byp_valid & ~conf_any) == '0);
    p_byp_not_read_r7: assert property (@(posedge clk) disable iff (rst)
        (byp_valid & grant) == '0);
    p_issued_set_r10: assert property (@(posedge clk) disable iff (rst)
        ((ld_issued & ~$past(ld_issued)) & ~($past(hs_vec) | $past(byp_valid))) == '0);
endmodule

// File: tb/ld_hazard_issue_tb_top.sv
`timescale 1ns/100ps
module ld_hazard_issue_tb_top;
    localparam int NL = 4;
    localparam int NS = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = $clog2(NL);
    localparam int SW = $clog2(NS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NL-1:0]         ld_alloc = '0, ld_addr_valid = '0, ld_clear = '0;
    logic [NL-1:0][AW-1:0] ld_addr = '0;
    logic [IW-1:0]         ld_head = '0;
    logic [NS-1:0]         st_alloc = '0, st_done = '0, st_addr_valid = '0, st_data_valid = '0;
    logic [NS-1:0][DW-1:0] st_data = '0;
    logic [SW-1:0]         st_head = '0;
    logic [NL-1:0][NS-1:0] st_older = '0, addr_same = '0;
    logic                  rd_ready = 1'b0;

    logic                  a_rv, b_rv;
    logic [AW-1:0]         a_ra, b_ra;
    logic [IW-1:0]         a_id, b_id;
    logic [NL-1:0]         a_bv, b_bv, a_iss, b_iss;
    logic [NL-1:0][DW-1:0] a_bd, b_bd;

    ld_hazard_issue #(.NL(NL), .NS(NS), .AW(AW), .DW(DW), .BYP_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .ld_alloc(ld_alloc), .ld_addr_valid(ld_addr_valid),
        .ld_addr(ld_addr), .ld_head(ld_head), .ld_clear(ld_clear), .st_alloc(st_alloc),
        .st_done(st_done), .st_addr_valid(st_addr_valid), .st_data_valid(st_data_valid),
        .st_data(st_data), .st_head(st_head), .st_older(st_older), .addr_same(addr_same),
        .rd_ready(rd_ready), .rd_valid(a_rv), .rd_addr(a_ra), .rd_id(a_id),
        .byp_valid(a_bv), .byp_data(a_bd), .ld_issued(a_iss));

    ld_hazard_issue #(.NL(NL), .NS(NS), .AW(AW), .DW(DW), .BYP_EN(1'b0)) dut_nb_i (
        .clk(clk), .rst(rst), .ld_alloc(ld_alloc), .ld_addr_valid(ld_addr_valid),
        .ld_addr(ld_addr), .ld_head(ld_head), .ld_clear(ld_clear), .st_alloc(st_alloc),
        .st_done(st_done), .st_addr_valid(st_addr_valid), .st_data_valid(st_data_valid),
        .st_data(st_data), .st_head(st_head), .st_older(st_older), .addr_same(addr_same),
        .rd_ready(rd_ready), .rd_valid(b_rv), .rd_addr(b_ra), .rd_id(b_id),
        .byp_valid(b_bv), .byp_data(b_bd), .ld_issued(b_iss));

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [NL-1:0] m_iss_a = '0, m_iss_b = '0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // behavioural model; walks stores from youngest to oldest
    task automatic model(input bit en, input logic [NL-1:0] iss,
                         output logic [NL-1:0] eb, output logic [NL-1:0][DW-1:0] ebd,
                         output bit ev, output int eid);
        bit ok [NL];
        for (int i = 0; i < NL; i++) begin
            int y = -1;
            bit anyc = 0;
            for (int k = NS - 1; k >= 0; k--) begin
                int j = (int'(st_head) + k) % NS;
                // R1 conflict rule
                if (st_alloc[j] && !st_done[j] && st_older[i][j] &&
                    (addr_same[i][j] || !st_addr_valid[j])) begin
                    anyc = 1;
                    if (y < 0) y = j;
                end
            end
            eb[i] = 1'b0;
            ebd[i] = '0;
            if (anyc) begin
                eb[i] = en && ld_alloc[i] && ld_addr_valid[i] && !iss[i] &&
                        addr_same[i][y] && st_addr_valid[y] && st_data_valid[y];
                ebd[i] = st_data[y];
            end
            ok[i] = ld_alloc[i] && ld_addr_valid[i] && !iss[i] && !eb[i] && !anyc;
        end
        ev = 0;
        eid = 0;
        for (int k = NL - 1; k >= 0; k--) begin
            int idx = (int'(ld_head) + k) % NL;
            if (ok[idx]) begin ev = 1; eid = idx; end
        end
    endtask

    task automatic check_one(input string tag, input bit en, inout logic [NL-1:0] miss,
                             input logic rv, input logic [AW-1:0] ra, input logic [IW-1:0] id,
                             input logic [NL-1:0] bv, input logic [NL-1:0][DW-1:0] bd,
                             input logic [NL-1:0] iss);
        logic [NL-1:0] eb;
        logic [NL-1:0][DW-1:0] ebd;
        bit ev;
        int eid;
        model(en, miss, eb, ebd, ev, eid);
        chk(iss == miss, {tag, " R10 issued bits"}, iss, miss);
        chk(rv == ev, {tag, " R7 rd_valid"}, rv, ev);
        if (ev) begin
            chk(int'(id) == eid, {tag, " R8 rd_id winner"}, id, eid);
            chk(ra == ld_addr[eid], {tag, " R9 rd_addr"}, ra, ld_addr[eid]);
        end
        chk(bv == eb, en ? {tag, " R3 byp_valid"} : {tag, " R6 byp_valid"}, bv, eb);
        for (int i = 0; i < NL; i++)
            if (eb[i]) chk(bd[i] == ebd[i], {tag, " R3 byp_data"}, bd[i], ebd[i]);
        miss = (miss | eb | ((ev && rd_ready) ? NL'(1) << eid : '0)) & ~ld_clear;
    endtask

    task automatic step(input string tag);
        #1;
        check_one({tag, " fwd"}, 1'b1, m_iss_a, a_rv, a_ra, a_id, a_bv, a_bd, a_iss);
        check_one({tag, " nofwd"}, 1'b0, m_iss_b, b_rv, b_ra, b_id, b_bv, b_bd, b_iss);
        @(negedge clk);
    endtask

    task automatic quiet();
        ld_alloc = '0; ld_addr_valid = '0; ld_clear = '1; st_alloc = '0;
        st_done = '0; st_addr_valid = '0; st_data_valid = '0; st_older = '0;
        addr_same = '0; rd_ready = 1'b0; ld_head = '0; st_head = '0;
        step("clear");
        ld_clear = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(a_iss == '0 && b_iss == '0, "R11 issued after reset", {a_iss, b_iss}, 0);
        chk(!a_rv && !b_rv, "R11 no request in reset", {a_rv, b_rv}, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NL; i++) ld_addr[i] = AW'(8'h10 + i);
        for (int j = 0; j < NS; j++) st_data[j] = DW'(16'hA000 + j);

        // R4: youngest older store has unknown address
        ld_alloc = 4'b0001; ld_addr_valid = 4'b0001;
        st_alloc = 4'b0011; st_older[0] = 4'b0011; addr_same[0] = 4'b0001;
        st_addr_valid = 4'b0001; st_data_valid = 4'b0011;
        step("R4");
        // R3: youngest store now matches with data
        st_addr_valid = 4'b0011; addr_same[0] = 4'b0011;
        step("R3");
        step("R10 after forward");
        quiet();
        // R1: completed store no longer blocks; R6 case reads too
        ld_alloc = 4'b0001; ld_addr_valid = 4'b0001; st_alloc = 4'b0010;
        st_older[0] = 4'b0010; addr_same[0] = 4'b0010; st_addr_valid = 4'b0010;
        st_done = 4'b0010; rd_ready = 1'b1;
        step("R1");
        quiet();
        // R5: address not valid, matching store present
        ld_alloc = 4'b0001; ld_addr_valid = 4'b0000; st_alloc = 4'b0001;
        st_older[0] = 4'b0001; addr_same[0] = 4'b0001; st_addr_valid = 4'b0001;
        st_data_valid = 4'b0001;
        step("R5");
        quiet();
        // R8: head at 2, wrap; held without ready, then accepted
        ld_alloc = 4'b1111; ld_addr_valid = 4'b1011; ld_head = 2'd2;
        step("R8 hold");
        step("R10 no ready");
        rd_ready = 1'b1;
        step("R8 accept");
        step("R8 next");
        step("R8 wrap");
        // R2: conflicted load skipped
        quiet();
        ld_alloc = 4'b0011; ld_addr_valid = 4'b0011; st_alloc = 4'b0100;
        st_older[0] = 4'b0100; addr_same[0] = 4'b0000; st_addr_valid = 4'b0000;
        rd_ready = 1'b0;
        step("R2");
        quiet();

        for (int c = 0; c < 1500; c++) begin
            ld_alloc = NL'($urandom);
            ld_addr_valid = NL'($urandom | $urandom);
            ld_clear = NL'($urandom & $urandom & $urandom);
            ld_head = IW'($urandom);
            st_head = SW'($urandom);
            st_alloc = NS'($urandom | $urandom);
            st_done = NS'($urandom & $urandom);
            st_addr_valid = NS'($urandom | $urandom);
            st_data_valid = NS'($urandom | $urandom);
            for (int i = 0; i < NL; i++) begin
                st_older[i] = NS'($urandom);
                addr_same[i] = NS'($urandom & $urandom);
                ld_addr[i] = AW'($urandom);
            end
            for (int j = 0; j < NS; j++) st_data[j] = DW'($urandom);
            rd_ready = ($urandom % 4) != 0;
            step("random");
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule